// File: doc/BRIEF.md
# Programmable Down Counter/Timer

This block is a 16-bit down counter. It restarts from a loadable start value and shapes its output. Software reaches it through a small byte-wide register bus. A trigger loads the start value and starts a count. The count falls by one on each count tick, but only while the gate conditions hold. On reaching terminal count the block either reloads and runs again or stops, depending on the mode.

The count tick, the gate and the trigger can each come from an external pin, enabled one by one in the mode register. A derived waveform (pulse, one-shot or square wave) can drive an output pin. A separate one-clock terminal-count strobe is always available to surrounding logic. Software can freeze a copy of the running count and then read it safely as two bytes.

Top module: `ptimer16`

## Requirements
- R1: After reset, every register reads 0x00, no count is in progress, and `ext_out` and `tc_pulse` are low.
- R2: Register addresses are 0 for mode, 1 for command/status, 2 and 3 for the count upper and lower bytes, and 4 and 5 for the start value upper and lower bytes. Each start-value byte is written separately and reads back as written. Addresses 6 and 7 read 0x00.
- R3: A trigger loads the start value on the next clock and sets count-in-progress (status bit 0). A trigger is a write of 1 to command bit 1, or a rising edge on `ext_trig_in` when mode bit 4 is 1. Command bit 1 always reads 0.
- R4: The count decrements only while command bit 2 (software gate, readable) is 1, and also `ext_gate_in` is 1 when mode bit 3 is 1. Otherwise the count holds.
- R5: With mode bit 5 at 0, a count tick occurs on every clock. With mode bit 5 at 1, a tick occurs once for each rising edge of `ext_cnt_in`.
- R6: A tick taken at count 1 is terminal count, and `tc_pulse` is high for exactly the following clock. With mode bit 7 at 1 the start value is reloaded. With mode bit 7 at 0 the count goes to 0 and count-in-progress clears.
- R7: A trigger during a count restarts the count only when mode bit 2 is 1; otherwise it is ignored.
- R8: Shape code 0 in mode bits 1:0 (pulse) makes the waveform high for the one clock after each terminal count. Code 3 behaves exactly as code 0.
- R9: Shape code 1 (one-shot) makes the waveform high from the clock after a loading trigger until the clock after terminal count.
- R10: Shape code 2 (square wave) loads half the start value (start value shifted right by one) and inverts the waveform after each terminal count.
- R11: `ext_out` carries the waveform when mode bit 6 is 1 and is held low when it is 0.
- R12: Writing 1 to command bit 3 freezes a copy of the count, and status bit 3 reads 1 while it is frozen. Count reads return the frozen copy until the lower count byte is read, which releases it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for freeze release) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| ext_cnt_in | input | 1 | External count tick source |
| ext_gate_in | input | 1 | External gate |
| ext_trig_in | input | 1 | External trigger |
| ext_out | output | 1 | Shaped waveform output |
| tc_pulse | output | 1 | One-clock terminal-count strobe |

## Verification
The counter is driven with clock ticks and with sparse external edges. This separates the per-clock path from the edge-detected path. Gate closures by software and by the pin show whether holding and decrementing are wired to the right conditions.

Triggers are given at three points: idle, mid-count with restart enabled, and mid-count with restart disabled. These expose the loading priority. Each of the four shape codes is run in single and continuous cycling. This tells the half-value reload and the toggling apart from the pulse and one-shot timing.

A frozen count is read several times while the live count moves on. This shows that the copy holds and that the release happens only on the lower-byte read.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

  typedef enum logic [1:0] {
    SHP_PULSE   = 2'd0,
    SHP_ONESHOT = 2'd1,
    SHP_SQUARE  = 2'd2,
    SHP_RSVD    = 2'd3
  } shape_e;

  // bit order is the register layout software relies on
  typedef struct packed {
    logic   continuous;
    logic   out_en;
    logic   cnt_en;
    logic   trg_en;
    logic   gate_en;
    logic   retrig;
    shape_e shape;
  } mode_t;

  localparam int REG_MODE  = 0;
  localparam int REG_CMD   = 1;
  localparam int REG_CNTHI = 2;
  localparam int REG_CNTLO = 3;
  localparam int REG_TCHI  = 4;
  localparam int REG_TCLO  = 5;

  localparam int CMD_RCC  = 3;
  localparam int CMD_GATE = 2;
  localparam int CMD_TRIG = 1;

endpackage

// File: rtl/ptimer_edge.sv
module ptimer_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig;
  end

  for (genvar i = 0; i < W; i++) begin : g_rise
    assign rise[i] = sig[i] & ~prev_q[i];
  end
endmodule

// File: rtl/ptimer_core.sv
module ptimer_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             gate_ok,
  input  logic             trig,
  input  logic             retrig,
  input  logic             continuous,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count_q,
  output logic             cip_q,
  output logic             tc_evt,
  output logic             ld
);
  logic [CNT_W-1:0] count_d;
  logic             cip_d;
  logic             step;

  always_comb begin
    step    = cip_q & gate_ok & tick;
    tc_evt  = step & (count_q == CNT_W'(1));
    ld      = trig & (~cip_q | retrig);
    count_d = count_q;
    cip_d   = cip_q;
    if (ld) begin
      count_d = load_val;
      cip_d   = 1'b1;
    end else if (tc_evt) begin
      if (continuous) begin
        count_d = load_val;
      end else begin
        count_d = '0;
        cip_d   = 1'b0;
      end
    end else if (step) begin
      count_d = count_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      cip_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      cip_q   <= cip_d;
    end
  end
endmodule

// File: rtl/ptimer_wave.sv
module ptimer_wave
  import ptimer_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  shape_e shape,
  input  logic   ld,
  input  logic   tc_evt,
  output logic   wave_q,
  output logic   tc_pulse_q
);
  logic wave_d;

  always_comb begin
    wave_d = wave_q;
    unique case (shape)
      SHP_ONESHOT: begin
        if (ld)          wave_d = 1'b1;
        else if (tc_evt) wave_d = 1'b0;
      end
      SHP_SQUARE: begin
        if (tc_evt) wave_d = ~wave_q;
      end
      default: wave_d = tc_evt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_q     <= 1'b0;
      tc_pulse_q <= 1'b0;
    end else begin
      wave_q     <= wave_d;
      tc_pulse_q <= tc_evt;
    end
  end
endmodule

// File: rtl/ptimer16.sv
module ptimer16
  import ptimer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ext_cnt_in,
  input  logic              ext_gate_in,
  input  logic              ext_trig_in,
  output logic              ext_out,
  output logic              tc_pulse
);
  localparam int CNT_W = 2 * DATA_W;

  mode_t             mode_q, mode_d;
  logic [CNT_W-1:0]  tc_q, tc_d;
  logic [CNT_W-1:0]  snap_q, snap_d;
  logic              gate_q, gate_d;
  logic              frozen_q, frozen_d;

  logic [CNT_W-1:0]  count_q, load_val, cnt_view;
  logic              cip_q, tc_evt, ld, wave_q;
  logic [1:0]        rise;
  logic              wr_cmd, rd_lo, tick, trig, gate_ok;

  ptimer_edge #(.W(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  ({ext_trig_in, ext_cnt_in}),
    .rise (rise)
  );

  assign wr_cmd   = wr_en & (addr == ADDR_W'(REG_CMD));
  assign rd_lo    = rd_en & (addr == ADDR_W'(REG_CNTLO));
  assign tick     = mode_q.cnt_en ? rise[0] : 1'b1;
  assign trig     = (wr_cmd & wdata[CMD_TRIG]) | (mode_q.trg_en & rise[1]);
  assign gate_ok  = gate_q & (~mode_q.gate_en | ext_gate_in);
  assign load_val = (mode_q.shape == SHP_SQUARE) ? (tc_q >> 1) : tc_q;

  ptimer_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .gate_ok   (gate_ok),
    .trig      (trig),
    .retrig    (mode_q.retrig),
    .continuous(mode_q.continuous),
    .load_val  (load_val),
    .count_q   (count_q),
    .cip_q     (cip_q),
    .tc_evt    (tc_evt),
    .ld        (ld)
  );

  ptimer_wave u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .shape     (mode_q.shape),
    .ld        (ld),
    .tc_evt    (tc_evt),
    .wave_q    (wave_q),
    .tc_pulse_q(tc_pulse)
  );

  // register next state
  always_comb begin
    mode_d   = mode_q;
    tc_d     = tc_q;
    gate_d   = gate_q;
    frozen_d = frozen_q;
    snap_d   = snap_q;
    if (wr_en) begin
      case (addr)
        ADDR_W'(REG_MODE): mode_d = mode_t'(wdata);
        ADDR_W'(REG_CMD):  gate_d = wdata[CMD_GATE];
        ADDR_W'(REG_TCHI): tc_d[CNT_W-1:DATA_W] = wdata;
        ADDR_W'(REG_TCLO): tc_d[DATA_W-1:0] = wdata;
        default: ;
      endcase
    end
    if (wr_cmd & wdata[CMD_RCC]) begin
      frozen_d = 1'b1;
      snap_d   = count_q;
    end else if (rd_lo & frozen_q) begin
      frozen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      tc_q     <= '0;
      gate_q   <= 1'b0;
      frozen_q <= 1'b0;
      snap_q   <= '0;
    end else begin
      mode_q   <= mode_d;
      tc_q     <= tc_d;
      gate_q   <= gate_d;
      frozen_q <= frozen_d;
      snap_q   <= snap_d;
    end
  end

  assign cnt_view = frozen_q ? snap_q : count_q;
  assign ext_out  = mode_q.out_en & wave_q;

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(REG_MODE):  rdata = mode_q;
      ADDR_W'(REG_CMD): begin
        rdata[CMD_RCC]  = frozen_q;
        rdata[CMD_GATE] = gate_q;
        rdata[0]        = cip_q;
      end
      ADDR_W'(REG_CNTHI): rdata = cnt_view[CNT_W-1:DATA_W];
      ADDR_W'(REG_CNTLO): rdata = cnt_view[DATA_W-1:0];
      ADDR_W'(REG_TCHI):  rdata = tc_q[CNT_W-1:DATA_W];
      ADDR_W'(REG_TCLO):  rdata = tc_q[DATA_W-1:0];
      default: ;
    endcase
  end
endmodule

// File: rtl/ptimer16_chk.sv
module ptimer16_chk
  import ptimer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   wdata,
  input logic                tc_pulse,
  input logic                cip_q,
  input logic                ld,
  input logic                tc_evt,
  input logic                continuous,
  input logic [1:0]          shape,
  input logic                gate_q,
  input logic                wave_q,
  input logic                frozen_q,
  input logic [2*DATA_W-1:0] count_q,
  input logic [2*DATA_W-1:0] snap_q
);
  logic rd_lo, wr_rcc;
  assign rd_lo  = rd_en & (addr == ADDR_W'(REG_CNTLO));
  assign wr_rcc = wr_en & (addr == ADDR_W'(REG_CMD)) & wdata[CMD_RCC];

  // R3
  trig_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cip_q);

  // R6
  tc_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> $past(cip_q));

  // R6
  single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_evt && !continuous && !ld) |=> !cip_q);

  // R4
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_q && !ld) |=> (count_q == $past(count_q)));

  // R10
  square_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_evt && shape == 2'd2) |=> (wave_q != $past(wave_q)));

  // R12
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_q && !rd_lo && !wr_rcc) |=> (frozen_q && $stable(snap_q)));
endmodule

bind ptimer16 ptimer16_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .wdata     (wdata),
  .tc_pulse  (tc_pulse),
  .cip_q     (cip_q),
  .ld        (ld),
  .tc_evt    (tc_evt),
  .continuous(mode_q.continuous),
  .shape     (mode_q.shape),
  .gate_q    (gate_q),
  .wave_q    (wave_q),
  .frozen_q  (frozen_q),
  .count_q   (count_q),
  .snap_q    (snap_q)
);

// File: tb/tb_ptimer16.sv
module tb_ptimer16;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ext_cnt_in = 1'b0, ext_gate_in = 1'b0, ext_trig_in = 1'b0;
  logic       ext_out, tc_pulse;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;

  ptimer16 dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_cnt_in(ext_cnt_in),
    .ext_gate_in(ext_gate_in), .ext_trig_in(ext_trig_in),
    .ext_out(ext_out), .tc_pulse(tc_pulse)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  int       m_cnt, m_snap, m_tc;
  bit       m_cip, m_wave, m_tcp, m_frz, m_gate, m_pc, m_pt;
  bit [7:0] m_mode;

  always @(posedge clk or negedge rst_n) begin : model
    bit tick, trg, gok, tcev, ld;
    int ldval, shp;
    if (!rst_n) begin
      m_cnt = 0; m_snap = 0; m_tc = 0; m_cip = 0; m_wave = 0; m_tcp = 0;
      m_frz = 0; m_gate = 0; m_pc = 0; m_pt = 0; m_mode = 0;
    end else begin
      tick  = m_mode[5] ? (ext_cnt_in && !m_pc) : 1'b1;
      trg   = (wr_en && addr == 3'd1 && wdata[1]) || (m_mode[4] && ext_trig_in && !m_pt);
      gok   = m_gate && (!m_mode[3] || ext_gate_in);
      tcev  = m_cip && gok && tick && m_cnt == 1;
      ld    = trg && (!m_cip || m_mode[2]);
      shp   = (m_mode[1:0] == 2'd3) ? 0 : int'(m_mode[1:0]);
      ldval = (shp == 2) ? m_tc / 2 : m_tc;
      if (wr_en && addr == 3'd1 && wdata[3]) begin m_frz = 1; m_snap = m_cnt; end
      else if (rd_en && addr == 3'd3 && m_frz) m_frz = 0;
      if (shp == 1) begin
        if (ld) m_wave = 1; else if (tcev) m_wave = 0;
      end else if (shp == 2) begin
        if (tcev) m_wave = !m_wave;
      end else m_wave = tcev;
      m_tcp = tcev;
      if (ld) begin m_cnt = ldval; m_cip = 1; end
      else if (tcev) begin
        if (m_mode[7]) m_cnt = ldval; else begin m_cnt = 0; m_cip = 0; end
      end else if (m_cip && gok && tick) m_cnt = (m_cnt + 65535) % 65536;
      if (wr_en) begin
        case (addr)
          3'd0: m_mode = wdata;
          3'd1: m_gate = wdata[2];
          3'd4: m_tc = (m_tc % 256) + 256 * int'(wdata);
          3'd5: m_tc = (m_tc / 256) * 256 + int'(wdata);
          default: ;
        endcase
      end
      m_pc = ext_cnt_in;
      m_pt = ext_trig_in;
    end
  end

  function automatic int m_read(input int a);
    int v;
    v = m_frz ? m_snap : m_cnt;
    case (a)
      0: return int'(m_mode);
      1: return (m_frz ? 8 : 0) + (m_gate ? 4 : 0) + (m_cip ? 1 : 0);
      2: return v / 256;
      3: return v % 256;
      4: return m_tc / 256;
      5: return m_tc % 256;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle output comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(tc_pulse == m_tcp, "R6 tc_pulse", int'(tc_pulse), int'(m_tcp));
      chk(ext_out == (m_mode[6] & m_wave), "R8/R9/R10/R11 ext_out",
          int'(ext_out), int'(m_mode[6] & m_wave));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); #2;
    wr_en = 1'b1; addr = 3'(a); wdata = 8'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // read, compare against model, return value
  task automatic rd(input int a, input string tag, output int val);
    int e;
    @(negedge clk); #2;
    rd_en = 1'b1; addr = 3'(a);
    #6;
    e = m_read(a);
    val = int'(rdata);
    chk(val == e, tag, val, e);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic rd_exp(input int a, input int exp, input string tag);
    int v;
    rd(a, tag, v);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ext_ticks(input int n);
    repeat (n) begin
      @(negedge clk); #2 ext_cnt_in = 1'b1;
      @(negedge clk); #2 ext_cnt_in = 1'b0;
      idle(1);
    end
  endtask

  initial begin : watchdog
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int v1, v2;
    idle(3);
    @(negedge clk); #2 rst_n = 1'b1;
    idle(1);
    chk(ext_out == 1'b0 && tc_pulse == 1'b0, "R1 outputs after reset",
        int'({ext_out, tc_pulse}), 0);
    for (int a = 0; a < 8; a++) rd_exp(a, 0, "R1/R2 reset read");
    cmp_on = 1;

    // R2 start value bytes
    wr(4, 8'h12); wr(5, 8'h34);
    rd_exp(4, 8'h12, "R2 tc upper byte");
    rd_exp(5, 8'h34, "R2 tc lower byte");
    wr(4, 0); wr(5, 4);
    rd_exp(5, 4, "R2 tc lower rewrite");

    // R3 R6 R8 continuous pulse
    wr(0, 8'hC0);
    wr(1, 8'h06);
    rd_exp(1, 8'h05, "R3 status after trigger");
    idle(20);
    rd(3, "R6 count continuous", v1);

    // R6 single cycle stops
    wr(0, 8'h40);
    idle(10);
    rd_exp(1, 8'h04, "R6 single cycle cleared cip");
    rd_exp(3, 0, "R6 single cycle count zero");

    // R4 gate closed holds
    wr(1, 8'h02);
    rd_exp(3, 4, "R4 loaded, gate closed");
    idle(5);
    rd_exp(3, 4, "R4 count held with gate closed");

    // R4 external gate
    wr(0, 8'h48);
    wr(1, 8'h04);
    idle(4);
    rd_exp(3, 4, "R4 held by ext gate low");
    @(negedge clk); #2 ext_gate_in = 1'b1;
    idle(10);
    rd_exp(1, 8'h04, "R4 ran out with ext gate high");
    @(negedge clk); #2 ext_gate_in = 1'b0;

    // R5 external count source
    wr(5, 3);
    wr(0, 8'h60);
    wr(1, 8'h06);
    idle(5);
    rd_exp(3, 3, "R5 no ticks without ext edges");
    ext_ticks(1);
    rd_exp(3, 2, "R5 one ext edge one tick");
    ext_ticks(3);
    rd_exp(1, 8'h04, "R5 finished on ext edges");

    // R3 external trigger
    wr(0, 8'h50);
    @(negedge clk); #2 ext_trig_in = 1'b1;
    idle(2);
    rd(1, "R3 ext trigger status", v1);
    chk(v1[0] == 1'b1, "R3 ext trigger sets cip", v1[0], 1);
    @(negedge clk); #2 ext_trig_in = 1'b0;
    idle(8);

    // R7 retrigger enabled / disabled
    wr(5, 6);
    wr(0, 8'hC4);
    wr(1, 8'h06);
    idle(2);
    wr(1, 8'h06);
    rd(3, "R7 retrigger restarts", v1);
    chk(v1 == 6, "R7 retrigger reload", v1, 6);
    wr(0, 8'hC0);
    idle(1);
    wr(1, 8'h06);
    rd(3, "R7 trigger ignored", v1);
    idle(12);

    // R9 one-shot
    wr(0, 8'h41);
    idle(14);
    wr(1, 8'h06);
    idle(12);

    // R10 square wave, half reload
    wr(5, 10);
    wr(0, 8'hC2);
    wr(1, 8'h02);
    rd_exp(3, 5, "R10 half start value loaded");
    wr(1, 8'h04);
    idle(30);

    // R8 reserved shape acts as pulse
    wr(0, 8'hC3);
    idle(15);

    // R11 output disabled
    wr(0, 8'h82);
    idle(12);
    chk(ext_out == 1'b0, "R11 ext_out low when disabled", int'(ext_out), 0);

    // R12 freeze and release
    wr(0, 8'hC0);
    wr(5, 200);
    wr(1, 8'h06);
    idle(3);
    wr(1, 8'h0C);
    rd(2, "R12 frozen upper", v1);
    idle(4);
    rd(2, "R12 frozen upper again", v2);
    chk(v1 == v2, "R12 frozen upper stable", v2, v1);
    rd(1, "R12 status frozen", v1);
    chk(v1[3] == 1'b1, "R12 freeze flag", v1[3], 1);
    rd(3, "R12 frozen lower", v1);
    rd(3, "R12 live lower after release", v2);
    chk(v1 != v2, "R12 released copy", v2, v1);
    rd(1, "R12 status released", v1);
    chk(v1[3] == 1'b0, "R12 freeze flag cleared", v1[3], 0);

    idle(5);
    cmp_on = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule